// File: doc/BRIEF.md
# Cycle-Counting Tone Burst Gate Controller

This block produces the two gate enables for a tone-burst generator. A one-bit zero-crossing indication from an external comparator is synchronized, and each rising edge is counted as one cycle of the test tone. The block alternates between a full-level phase (`on_gate_o` high) and a reduced-level phase (`off_gate_o` high). The length of each phase is a power-of-two number of tone cycles, chosen by two selectors. Because time is measured in tone cycles and not in clock ticks, burst timing follows the tone frequency, and every gate transition falls on a crossing of the tone.

A single-shot mode holds both enables low until a debounced burst request arrives. After the request the block waits one programmed reduced-level length, still silent, and then opens the full-level gate for one programmed phase. It then returns to silence. A one-clock sync pulse marks the start of every full-level phase, for triggering a scope. The selector and mode inputs are synchronous to `clk_i`. `zc_i` and `burst_req_i` may be asynchronous.

Top module: `tbg_gate`

## Requirements
- R1: The cycle counter advances exactly once for each rising edge of `zc_i`, however long `zc_i` stays high. The gate outputs change only in the clock after a synchronized crossing event, except in the single-shot idle exit described in R7.
- R2: The full-level phase lasts 2^s tone cycles for `on_sel_i` = s in 0..5. Any value above 5 gives 32 cycles.
- R3: The reduced-level phase (and the single-shot wait) lasts 2^(s+2) tone cycles for `off_sel_i` = s, so 0 gives 4 and 4 gives 64. Values of 11 and above give 8192 cycles.
- R4: When the count reaches the length of the current phase, the phase changes and the next phase counts from zero.
- R5: `on_gate_o` and `off_gate_o` are never high together. `on_gate_o` is high only in the full-level phase and `off_gate_o` only in the reduced-level phase.
- R6: A reduced-level length shorter than the full-level length works with no restriction on the ratio.
- R7: With `single_i` = 1, the block leaves a completed phase for an idle state with both gates low. An accepted request starts a silent wait of one reduced-level length, then one full-level phase, then idle again. Clearing `single_i` while idle starts a reduced-level phase on the next clock.
- R8: A burst request made while a single-shot wait or burst is running is ignored.
- R9: `sync_o` is high for exactly one clock at the start of each full-level phase, and at no other time.
- R10: After reset the block is in the reduced-level phase with its count at zero and `sync_o` low. The first clock after reset loads the reduced-level length.
- R11: The selectors are sampled only at phase boundaries. A change in the middle of a phase has no effect until the next boundary. A value present on the clock that processes the completing crossing applies to the phase that starts there.
- R12: A burst request must stay stable for DB_CYCLES clocks to be accepted. A shorter pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| zc_i | input | 1 | Asynchronous zero-crossing indication from the tone comparator |
| on_sel_i | input | ON_SEL_W | Full-level length exponent |
| off_sel_i | input | OFF_SEL_W | Reduced-level length exponent, offset by two |
| single_i | input | 1 | 1 = single-shot mode, 0 = continuous |
| burst_req_i | input | 1 | Asynchronous burst request, for example a pushbutton |
| on_gate_o | output | 1 | Enable for the full-level tone path |
| off_gate_o | output | 1 | Enable for the reduced-level tone path |
| sync_o | output | 1 | One-clock pulse at the start of each full-level phase |

## Verification
Two things can fall on the same clock: a selector change and the crossing that closes a phase. To provoke this, the bench writes new selector values after the synchronizer has passed the edge but before the counting clock. It then expects the new phase to follow the new value, per R11. A second case is a burst request that lands while a single-shot sequence is running. The bench judges that the burst keeps its length, that only one sync pulse appears, and that the block returns to a silent idle.

// File: rtl/tbg_pkg.sv
package tbg_pkg;
  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_ON   = 2'd1,
    PH_IDLE = 2'd2,
    PH_WAIT = 2'd3
  } phase_e;
endpackage

// File: rtl/tbg_sync_edge.sv
module tbg_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  // STAGES synchronizer flops plus one history flop for edge detect
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tbg_debounce.sv
module tbg_debounce #(
  parameter int unsigned STAGES    = 2,
  parameter int unsigned DB_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic rise_o
);
  localparam int unsigned DB_W = $clog2(DB_CYCLES + 1);
  localparam logic [DB_W-1:0] DB_LAST = DB_W'(DB_CYCLES - 1);

  logic [STAGES-1:0] sync_q;
  logic              lvl, stable_q, rise_q;
  logic [DB_W-1:0]   cnt_q;

  assign lvl = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= '0;
      stable_q <= 1'b0;
      cnt_q    <= '0;
      rise_q   <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], raw_i};
      rise_q <= 1'b0;
      if (lvl == stable_q) begin
        cnt_q <= '0;
      end else if (cnt_q == DB_LAST) begin
        stable_q <= lvl;
        cnt_q    <= '0;
        rise_q   <= lvl;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rise_o = rise_q;
endmodule

// File: rtl/tbg_phase_fsm.sv
module tbg_phase_fsm
  import tbg_pkg::*;
#(
  parameter int unsigned ON_SEL_W     = 3,
  parameter int unsigned OFF_SEL_W    = 4,
  parameter int unsigned ON_MAX_LOG2  = 5,
  parameter int unsigned OFF_MIN_LOG2 = 2,
  parameter int unsigned OFF_MAX_LOG2 = 13,
  parameter int unsigned CNT_W        = OFF_MAX_LOG2 + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ev_i,
  input  logic                 req_i,
  input  logic                 single_i,
  input  logic [ON_SEL_W-1:0]  on_sel_i,
  input  logic [OFF_SEL_W-1:0] off_sel_i,
  output phase_e               phase_o,
  output logic                 sync_o
);
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, len_q, len_d, cnt_inc;
  logic [CNT_W-1:0] on_len, off_len;
  logic [31:0]      on_e, off_e;
  logic             init_q, sync_q, sync_d;

  always_comb begin
    on_e    = (32'(on_sel_i) > ON_MAX_LOG2) ? ON_MAX_LOG2 : 32'(on_sel_i);
    off_e   = 32'(off_sel_i) + OFF_MIN_LOG2;
    off_e   = (off_e > OFF_MAX_LOG2) ? OFF_MAX_LOG2 : off_e;
    on_len  = CNT_W'(1) << on_e;
    off_len = CNT_W'(1) << off_e;
  end

  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    sync_d  = 1'b0;
    if (init_q) begin
      len_d = off_len;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (!single_i) begin
            phase_d = PH_OFF;
            cnt_d   = '0;
            len_d   = off_len;
          end else if (req_i) begin
            phase_d = PH_WAIT;
            cnt_d   = '0;
            len_d   = off_len;
          end
        end
        default: begin
          if (ev_i) begin
            if (cnt_inc == len_q) begin
              cnt_d = '0;
              unique case (phase_q)
                PH_ON:   phase_d = single_i ? PH_IDLE : PH_OFF;
                PH_OFF:  phase_d = single_i ? PH_IDLE : PH_ON;
                default: phase_d = PH_ON;
              endcase
              if (phase_d == PH_ON) begin
                len_d  = on_len;
                sync_d = 1'b1;
              end else begin
                len_d = off_len;
              end
            end else begin
              cnt_d = cnt_inc;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_OFF;
      cnt_q   <= '0;
      len_q   <= '0;
      init_q  <= 1'b1;
      sync_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      init_q  <= 1'b0;
      sync_q  <= sync_d;
    end
  end

  assign phase_o = phase_q;
  assign sync_o  = sync_q;
endmodule

// File: rtl/tbg_gate.sv
module tbg_gate
  import tbg_pkg::*;
#(
  parameter int unsigned ON_SEL_W     = 3,
  parameter int unsigned OFF_SEL_W    = 4,
  parameter int unsigned ON_MAX_LOG2  = 5,
  parameter int unsigned OFF_MIN_LOG2 = 2,
  parameter int unsigned OFF_MAX_LOG2 = 13,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned DB_CYCLES    = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 zc_i,
  input  logic [ON_SEL_W-1:0]  on_sel_i,
  input  logic [OFF_SEL_W-1:0] off_sel_i,
  input  logic                 single_i,
  input  logic                 burst_req_i,
  output logic                 on_gate_o,
  output logic                 off_gate_o,
  output logic                 sync_o
);
  localparam int unsigned CNT_W = OFF_MAX_LOG2 + 1;

  logic   zc_rise, req_rise;
  phase_e phase;

  tbg_sync_edge #(.STAGES(SYNC_STAGES)) u_zc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (zc_i),
    .rise_o(zc_rise)
  );

  tbg_debounce #(.STAGES(SYNC_STAGES), .DB_CYCLES(DB_CYCLES)) u_req (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (burst_req_i),
    .rise_o(req_rise)
  );

  tbg_phase_fsm #(
    .ON_SEL_W    (ON_SEL_W),
    .OFF_SEL_W   (OFF_SEL_W),
    .ON_MAX_LOG2 (ON_MAX_LOG2),
    .OFF_MIN_LOG2(OFF_MIN_LOG2),
    .OFF_MAX_LOG2(OFF_MAX_LOG2),
    .CNT_W       (CNT_W)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (zc_rise),
    .req_i    (req_rise),
    .single_i (single_i),
    .on_sel_i (on_sel_i),
    .off_sel_i(off_sel_i),
    .phase_o  (phase),
    .sync_o   (sync_o)
  );

  assign on_gate_o  = (phase == PH_ON);
  assign off_gate_o = (phase == PH_OFF);
endmodule

// File: rtl/tbg_gate_chk.sv
module tbg_gate_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       on_gate_i,
  input logic       off_gate_i,
  input logic       sync_i,
  input logic       ev_i,
  input logic       single_i,
  input logic [1:0] phase_i
);
  AST_GATE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(on_gate_i && off_gate_i)); // R5

  AST_SYNC_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> !sync_i); // R9

  AST_SYNC_AT_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(on_gate_i) |-> sync_i); // R9

  AST_ON_AT_CROSSING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_gate_i != $past(on_gate_i)) |-> $past(ev_i)); // R1

  AST_SHOT_FROM_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(on_gate_i) && $past(single_i)) |-> ($past(phase_i) == 2'd3)); // R7
endmodule

bind tbg_gate tbg_gate_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .on_gate_i (on_gate_o),
  .off_gate_i(off_gate_o),
  .sync_i    (sync_o),
  .ev_i      (zc_rise),
  .single_i  (single_i),
  .phase_i   (phase)
);

// File: tb/tbg_gate_tb.sv
module tbg_gate_tb;
  localparam int DB = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       zc = 1'b0;
  logic [2:0] on_sel = 3'd2;
  logic [3:0] off_sel = 4'd1;
  logic       single = 1'b0;
  logic       req = 1'b0;
  logic       on_gate, off_gate, sync;

  int checks = 0, errors = 0, sync_seen = 0;
  // model: 0 off, 1 on, 2 idle, 3 wait
  int mst, mcnt, mlen, msync;

  always #4 clk = ~clk;

  tbg_gate #(.DB_CYCLES(DB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .zc_i(zc), .on_sel_i(on_sel), .off_sel_i(off_sel),
    .single_i(single), .burst_req_i(req), .on_gate_o(on_gate), .off_gate_o(off_gate),
    .sync_o(sync)
  );

  always @(negedge clk) if (rst_n && sync) sync_seen++;

  function automatic int on_len(int s);
    return (s > 5) ? 32 : (1 << s);
  endfunction
  function automatic int off_len(int s);
    return (s + 2 > 13) ? 8192 : (1 << (s + 2));
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_state(string tag);
    #1;
    chk(on_gate == (mst == 1), {tag, " on_gate"}, on_gate, mst == 1);
    chk(off_gate == (mst == 0), {tag, " off_gate"}, off_gate, mst == 0);
    chk(sync_seen == msync, {tag, " sync count R9"}, sync_seen, msync);
  endtask

  task automatic m_step();
    if (mst == 2) return;
    mcnt++;
    if (mcnt == mlen) begin
      mcnt = 0;
      case (mst)
        0: mst = single ? 2 : 1;
        1: mst = single ? 2 : 0;
        default: mst = 1;
      endcase
      if (mst == 1) begin
        mlen = on_len(on_sel);
        msync++;
      end else mlen = off_len(off_sel);
    end
  endtask

  // one tone cycle; optional selector change lands on the counting clock
  task automatic xing(int hi, bit chg, int on_n, int off_n, string tag);
    @(negedge clk) zc = 1'b1;
    repeat (2) @(negedge clk);
    if (chg) begin
      on_sel  = 3'(on_n);
      off_sel = 4'(off_n);
    end
    m_step();
    repeat (hi) @(negedge clk);
    zc = 1'b0;
    repeat (3) @(negedge clk);
    check_state(tag);
  endtask

  task automatic press(int n, bit accept);
    @(negedge clk) req = 1'b1;
    repeat (n) @(negedge clk);
    req = 1'b0;
    repeat (DB + 8) @(negedge clk);
    if (accept && mst == 2 && single) begin
      mst = 3; mcnt = 0; mlen = off_len(off_sel);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd42));
    repeat (5) @(negedge clk);
    #1;
    chk(off_gate == 1'b1, "R10 reset off_gate", off_gate, 1);
    chk(on_gate == 1'b0, "R10 reset on_gate", on_gate, 0);
    chk(sync == 1'b0, "R10 reset sync", sync, 0);
    @(negedge clk) rst_n = 1'b1;
    mst = 0; mcnt = 0; mlen = off_len(off_sel); msync = 0;
    repeat (3) @(negedge clk);
    check_state("R10 after release");

    for (int i = 0; i < 40; i++) xing(2, 0, 0, 0, "R2 R3 R4 basic");

    on_sel = 3'd5; off_sel = 4'd0;
    for (int i = 0; i < 90; i++) xing(2, 0, 0, 0, "R6 short off");

    on_sel = 3'd7;
    for (int i = 0; i < 80; i++) xing(2, 0, 0, 0, "R2 clamp");

    on_sel = 3'd1; off_sel = 4'd1;
    for (int i = 0; i < 60 && !(mst == 0 && mcnt == mlen - 1); i++) xing(2, 0, 0, 0, "R4 seek");
    xing(2, 1, 3, 1, "R11 change at boundary");
    for (int i = 0; i < 12; i++) xing(2, 0, 0, 0, "R11 new on length");

    for (int i = 0; i < 6; i++) xing(40, 0, 0, 0, "R1 long high");

    for (int i = 0; i < 300; i++) begin
      bit c = ($urandom % 8) == 0;
      xing(2 + int'($urandom % 8), c, int'($urandom % 8), int'($urandom % 5), "R11 random");
    end

    single = 1'b1;
    for (int i = 0; i < 200 && mst != 2; i++) xing(2, 0, 0, 0, "R7 to idle");
    for (int i = 0; i < 5; i++) xing(2, 0, 0, 0, "R7 idle silent");
    press(3, 0);
    for (int i = 0; i < 6; i++) xing(2, 0, 0, 0, "R12 glitch ignored");
    on_sel = 3'd2; off_sel = 4'd0;
    press(DB + 6, 1);
    check_state("R7 wait silent");
    for (int i = 0; i < 6 && mst != 1; i++) xing(2, 0, 0, 0, "R7 wait");
    press(DB + 6, 1);
    check_state("R8 request in burst");
    for (int i = 0; i < 10; i++) xing(2, 0, 0, 0, "R7 R8 one burst");
    chk(mst == 2, "R8 back to idle", mst, 2);

    single = 1'b0;
    if (mst == 2) begin mst = 0; mcnt = 0; mlen = off_len(off_sel); end
    repeat (3) @(negedge clk);
    check_state("R7 leave single");

    off_sel = 4'd15; on_sel = 3'd0;
    for (int i = 0; i < 20 && !(mst == 0 && mlen == 8192); i++) xing(2, 0, 0, 0, "R3 seek long");
    for (int i = 0; i < 8200 && mst == 0; i++) xing(2, 0, 0, 0, "R3 8192 off");
    chk(mst == 1, "R3 long off ended", mst, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule